// File: doc/BRIEF.md
# Intra 16x16 Luma Predictor (Vertical, Horizontal, DC)

This block forms a 16x16 luma prediction from the reconstructed samples that border the block: the row above it and the column to its left. A two-bit mode code selects the prediction. Vertical copies the above row down the block. Horizontal spreads each left sample across its own row. DC fills the block with one rounded mean of whichever neighbour sets are marked available. The fourth code, plane, belongs to a different unit, so this block ignores it.

When a start strobe arrives while the block is idle, it captures the neighbours, the mode and the two availability flags. It then emits the prediction in raster order, one 16-sample row per cycle, for 16 consecutive cycles. A done pulse comes with the last row. Sample i of each input bus and column c of the row bus each occupy the eight bits starting at bit 8*i (or 8*c).

Top module: `intra16_pred`

## Requirements
- R1: After reset, row_valid and done are low and row_data is zero.
- R2: With mode 0 (vertical), every one of the 16 output rows equals the captured above bus.
- R3: With mode 1 (horizontal), every column of row r equals left sample r, the byte at bit 8*r of the left bus.
- R4: With mode 2 (DC) and both avail_up and avail_left high, every sample equals (sum of the 16 above + sum of the 16 left + 16) >> 5.
- R5: With mode 2 and exactly one of avail_up or avail_left high, every sample equals (sum of that set's 16 samples + 8) >> 4.
- R6: With mode 2 and both availability flags low, every sample is 128.
- R7: An accepted start yields exactly 16 consecutive valid rows, beginning in the cycle after the start edge. Done is high with row 15 only, and valid drops in the following cycle.
- R8: A start that arrives while rows are being emitted is ignored. The current rows, their data and their count are unchanged.
- R9: A start with mode 3 (plane) produces no valid row and no done pulse.
- R10: The sums cannot overflow. With all 32 neighbours at 255 and both flags high, the DC value is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a prediction when idle |
| mode | input | 2 | 0 vertical, 1 horizontal, 2 DC, 3 plane (ignored) |
| avail_up | input | 1 | Above neighbours usable for DC |
| avail_left | input | 1 | Left neighbours usable for DC |
| above | input | 128 | 16 above samples, sample i at bits 8i+7:8i |
| left | input | 128 | 16 left samples, sample i at bits 8i+7:8i |
| row_valid | output | 1 | A prediction row is on row_data |
| row_data | output | 128 | One row of 16 samples, column c at bits 8c+7:8c |
| done | output | 1 | High with the last row |

## Verification
A stuck or miscounting row counter appears at the ports in the first horizontal row that carries the wrong left sample. It also shifts the done pulse away from the sixteenth beat, or stretches or cuts the burst, so the fault is visible within 16 cycles of a start. A wrong DC sum or divisor gives a flat block with the wrong level from the first valid row. A start that wrongly restarts capture alters data or the beat count in the cycle after the stray strobe.

// File: rtl/intra16_pred.sv
module intra16_pred #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode,
  input  logic           avail_up,
  input  logic           avail_left,
  input  logic [N*W-1:0] above,
  input  logic [N*W-1:0] left,
  output logic           row_valid,
  output logic [N*W-1:0] row_data,
  output logic           done
);
  localparam int RW    = $clog2(N);
  localparam int LOG_N = $clog2(N);
  localparam int SUM_W = $clog2(2 * N * ((1 << W) - 1) + 1);
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic           busy;
  logic [RW-1:0]  row;
  logic [1:0]     mode_q;
  logic           up_q, lf_q;
  logic [N*W-1:0] above_q, left_q;
  logic [SUM_W-1:0] sum_up, sum_lf, dc_sum;
  logic [W-1:0]   dc;
  logic [N*W-1:0] pattern;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      row     <= '0;
      mode_q  <= '0;
      up_q    <= 1'b0;
      lf_q    <= 1'b0;
      above_q <= '0;
      left_q  <= '0;
    end else if (busy) begin
      row <= (row == LAST) ? '0 : row + 1'b1;
      if (row == LAST) busy <= 1'b0;
    end else if (start && mode != 2'd3) begin
      busy    <= 1'b1;
      row     <= '0;
      mode_q  <= mode;
      up_q    <= avail_up;
      lf_q    <= avail_left;
      above_q <= above;
      left_q  <= left;
    end
  end

  always_comb begin
    sum_up = '0;
    sum_lf = '0;
    for (int i = 0; i < N; i++) begin
      sum_up = sum_up + SUM_W'(above_q[i*W +: W]);
      sum_lf = sum_lf + SUM_W'(left_q[i*W +: W]);
    end
  end

  always_comb begin
    dc_sum = '0;
    dc     = W'(1 << (W - 1));
    case ({up_q, lf_q})
      2'b11: begin
        dc_sum = sum_up + sum_lf + SUM_W'(N);
        dc     = W'(dc_sum >> (LOG_N + 1));
      end
      2'b10: begin
        dc_sum = sum_up + SUM_W'(N / 2);
        dc     = W'(dc_sum >> LOG_N);
      end
      2'b01: begin
        dc_sum = sum_lf + SUM_W'(N / 2);
        dc     = W'(dc_sum >> LOG_N);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (mode_q)
      2'd0:    pattern = above_q;
      2'd1:    pattern = {N{left_q[row*W +: W]}};
      default: pattern = {N{dc}};
    endcase
  end

  assign row_valid = busy;
  assign row_data  = busy ? pattern : '0;
  assign done      = busy && (row == LAST);
endmodule

module intra16_pred_chk #(
  parameter int N = 16,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [1:0]     mode,
  input logic           busy,
  input logic [1:0]     mode_q,
  input logic           row_valid,
  input logic [N*W-1:0] row_data,
  input logic           done
);
  localparam int CW = $clog2(N) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!row_valid) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assert_done_row15_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> (done == (cnt == CW'(N - 1))));
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !row_valid);
  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !done) |=> row_valid);
  assert_vert_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !done && mode_q == 2'd0) |=> $stable(row_data));
  assert_dc_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && mode_q == 2'd2) |-> (row_data == {N{row_data[W-1:0]}}));
  assert_plane_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'd3) |=> !row_valid);
endmodule

bind intra16_pred intra16_pred_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .mode_q(mode_q), .row_valid(row_valid), .row_data(row_data), .done(done)
);

// File: tb/intra16_pred_tb.sv
`timescale 1ns/1ps
module intra16_pred_tb;
  localparam int N = 16;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic avail_up = 1'b0, avail_left = 1'b0;
  logic [N*W-1:0] above = '0, left = '0;
  logic row_valid, done;
  logic [N*W-1:0] row_data;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  intra16_pred #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .avail_up(avail_up), .avail_left(avail_left), .above(above), .left(left),
    .row_valid(row_valid), .row_data(row_data), .done(done)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] make_bus(input int seed, input int step);
    logic [N*W-1:0] b;
    for (int i = 0; i < N; i++) b[i*W +: W] = W'(seed + i * step);
    return b;
  endfunction

  function automatic int bus_sum(input logic [N*W-1:0] b);
    int s = 0;
    for (int i = 0; i < N; i++) s += int'(b[i*W +: W]);
    return s;
  endfunction

  task automatic kick(input logic [1:0] m, input logic up, input logic lf,
                      input logic [N*W-1:0] ab, input logic [N*W-1:0] lb);
    @(negedge clk);
    mode = m; avail_up = up; avail_left = lf; above = ab; left = lb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_burst(input string tag, input logic [1:0] m,
                              input logic [N*W-1:0] ab, input logic [N*W-1:0] lb,
                              input logic [W-1:0] dcv);
    logic [N*W-1:0] exp;
    for (int r = 0; r < N; r++) begin
      case (m)
        2'd0:    exp = ab;
        2'd1:    exp = {N{lb[r*W +: W]}};
        default: exp = {N{dcv}};
      endcase
      check(row_valid === 1'b1, {tag, " R7 valid"}, N*W'(row_valid), 1);
      check(row_data === exp, {tag, " data"}, row_data, exp);
      check(done === (r == N - 1), {tag, " R7 done"}, N*W'(done), N*W'(r == N - 1));
      @(negedge clk);
    end
    check(row_valid === 1'b0 && done === 1'b0, {tag, " R7 end"}, N*W'(row_valid), 0);
  endtask

  task automatic t_reset;
    check(row_valid === 1'b0 && done === 1'b0 && row_data === '0,
          "R1 reset", row_data, '0);
  endtask

  task automatic t_vertical;
    logic [N*W-1:0] ab = make_bus(8'h21, 13);
    logic [N*W-1:0] lb = make_bus(8'h90, 3);
    kick(2'd0, 1'b0, 1'b0, ab, lb);
    above = '0;
    expect_burst("R2 vertical", 2'd0, ab, lb, '0);
  endtask

  task automatic t_horizontal;
    logic [N*W-1:0] ab = make_bus(8'h05, 1);
    logic [N*W-1:0] lb = make_bus(8'hF0, 37);
    kick(2'd1, 1'b1, 1'b1, ab, lb);
    left = '0;
    expect_burst("R3 horizontal", 2'd1, ab, lb, '0);
  endtask

  task automatic t_dc(input string tag, input logic up, input logic lf,
                      input logic [N*W-1:0] ab, input logic [N*W-1:0] lb);
    int v;
    if (up && lf) v = (bus_sum(ab) + bus_sum(lb) + 16) >> 5;
    else if (up) v = (bus_sum(ab) + 8) >> 4;
    else if (lf) v = (bus_sum(lb) + 8) >> 4;
    else v = 128;
    kick(2'd2, up, lf, ab, lb);
    expect_burst(tag, 2'd2, ab, lb, W'(v));
  endtask

  task automatic t_plane;
    kick(2'd3, 1'b1, 1'b1, make_bus(1, 1), make_bus(2, 2));
    for (int k = 0; k < 4; k++) begin
      check(row_valid === 1'b0 && done === 1'b0, "R9 plane silent", N*W'(row_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy_ignore;
    logic [N*W-1:0] ab = make_bus(8'h11, 7);
    logic [N*W-1:0] lb = make_bus(8'h44, 9);
    logic [N*W-1:0] exp;
    kick(2'd1, 1'b0, 1'b0, ab, lb);
    for (int r = 0; r < N; r++) begin
      exp = {N{lb[r*W +: W]}};
      check(row_valid === 1'b1 && row_data === exp, "R8 busy data", row_data, exp);
      check(done === (r == N - 1), "R8 busy done", N*W'(done), N*W'(r == N - 1));
      if (r == 5) begin
        mode = 2'd0; above = make_bus(8'hAA, 1); left = make_bus(8'h00, 0); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(row_valid === 1'b0, "R8 no restart", N*W'(row_valid), 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vertical();
    t_horizontal();
    t_dc("R4 dc both", 1'b1, 1'b1, make_bus(8'h30, 11), make_bus(8'hC0, 5));
    t_dc("R5 dc up only", 1'b1, 1'b0, make_bus(8'h17, 19), make_bus(8'hFF, 0));
    t_dc("R5 dc left only", 1'b0, 1'b1, make_bus(8'h00, 0), make_bus(8'h03, 23));
    t_dc("R6 dc none", 1'b0, 1'b0, make_bus(8'h10, 2), make_bus(8'h20, 4));
    t_dc("R10 dc max", 1'b1, 1'b1, {N{8'hFF}}, {N{8'hFF}});
    t_plane();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule